// File: doc/BRIEF.md
# Complex NCO Down-Mixer

This block moves a real, digitized intermediate-frequency sample stream down to complex baseband. A numerically controlled oscillator keeps a 32-bit phase accumulator. The accumulator is stepped by a tuning word on every accepted sample. A static phase offset and an optional pseudo-random phase perturbation are added to it. The upper bits of the result address a quarter-wave sine table, and quadrant folding yields both sine and cosine from that one table. Each real input sample is multiplied by the cosine to form the in-phase output and by the negated sine to form the quadrature output. Both products are rounded and saturated to the output width.

Three write-only configuration registers are loaded through a simple write strobe: the tuning word, the phase offset, and two dither enables. The phase offset lets several mixers that share a clock keep a known phase relationship to each other. Phase dither and amplitude dither are enabled separately, and both trade a little broadband noise for lower spurious tones. The caller marks each input sample with a valid strobe, and the matching outputs appear with a fixed pipeline delay.

Top module: `nco_mixer`

## Requirements
- R1: A synchronous reset clears the accumulator, all three configuration registers, out_valid, out_i and out_q. The first sample after reset is therefore mixed at phase zero.
- R2: A write with cfg_we high loads the register selected by cfg_addr: 0 is the tuning word, 1 is the phase offset, and 2 holds the dither enables (bit 0 phase dither, bit 1 amplitude dither). Address 3 changes nothing. A write issued in the same cycle as a valid sample affects only later samples.
- R3: The lookup phase of an accepted sample equals the offset plus the sum, modulo 2^32, of the tuning words in force at each earlier accepted sample since reset. The accumulator does not move in cycles without in_valid.
- R4: Bits 31:20 of the phase address the waveform. Bits 31:30 select the quadrant and bits 29:20 index a quarter-wave table whose entry k is round(32767*sin(pi/2*k/1024)). Cosine at phase 0 is 32767 and sine at phase 0 is 0; sine is 32767 at phase 0x40000000 and -32767 at phase 0xC0000000.
- R5: out_i = sat16((x*cos + 16384) >>> 15) and out_q = sat16((x*(-sin) + 16384) >>> 15), where x is the signed 16-bit input sample.
- R6: out_valid is high exactly three clock cycles after each in_valid cycle, once per sample. out_i and out_q change only in cycles where out_valid is high.
- R7: When phase dither is enabled, a pseudo-random value in 0..4095 is added to the phase before bits 31:20 are taken. A phase whose low 20 bits are at most 0xFF000 is therefore never moved to another table entry. When phase dither is disabled, nothing is added.
- R8: When amplitude dither is enabled, one pseudo-random signed value in -4..3 is added to both sine and cosine of a sample before multiplication. When it is disabled, the table values are used unchanged.
- R9: A result outside the signed 16-bit range is clamped to -32768 or 32767 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Marks in_sample as a new sample |
| in_sample | input | 16 | Signed real input sample |
| out_valid | output | 1 | Marks a new complex output |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
The bench steps the phase by exact quarter turns and applies offsets of a half turn and a quarter turn. At these phases the sine and cosine are exactly 0 or ±32767, so a wrong quadrant fold, a sign error on the quadrature path, or an off-by-one in the mirrored index shows up as an output of the wrong sign or magnitude. It leaves gaps between samples and issues a write in the same cycle as a sample. An accumulator that runs freely, or a register write that takes effect too early, would shift every later phase by a quarter turn. For phase dither, the bench places the phase deep inside a table entry, where it must stay fixed, and then just below an entry boundary, where it must alternate between two known values. A dither sum that carries into the wrong bits would produce other values. Amplitude dither at full-scale negative input pushes the in-phase result past -32768. A design without clamping would wrap to a large positive number instead of tracking the quadrature result.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    typedef enum logic [1:0] {
        REG_FREQ  = 2'd0,
        REG_OFFS  = 2'd1,
        REG_DITH  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    localparam int              LFSR_W    = 32;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h0040_0007;

endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
    import nco_mix_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 12,
    parameter int PD_W    = 12,
    parameter int AD_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      adv,
    input  logic [PHASE_W-1:0]        freq,
    input  logic [PHASE_W-1:0]        offs,
    input  logic                      pd_en,
    input  logic                      ad_en,
    output logic [ADDR_W-1:0]         addr,
    output logic signed [AD_W-1:0]    amp_dith,
    output logic [PHASE_W-1:0]        acc_out
);
    localparam int SHIFT = PHASE_W - ADDR_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [LFSR_W-1:0]  lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [PHASE_W-1:0] pdith;
    logic [PHASE_W-1:0] phase;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.acc  = st_q.acc + freq;
            st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], 1'b0}
                        ^ (st_q.lfsr[LFSR_W-1] ? LFSR_TAPS : '0);
        end
        pdith    = pd_en ? PHASE_W'(st_q.lfsr[PD_W-1:0]) : '0;
        phase    = st_q.acc + offs + pdith;
        addr     = ADDR_W'(phase >> SHIFT);
        amp_dith = ad_en ? signed'(st_q.lfsr[LFSR_W-1 -: AD_W]) : '0;
        acc_out  = st_q.acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc  <= '0;
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut #(
    parameter int ADDR_W = 12,
    parameter int LUT_W  = 16
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [LUT_W-1:0] sin_v,
    output logic signed [LUT_W-1:0] cos_v
);
    localparam int  QW      = ADDR_W - 2;
    localparam int  QN      = 1 << QW;
    localparam int  AMP     = (1 << (LUT_W - 1)) - 1;
    localparam real HALF_PI = 1.5707963267948966;

    logic signed [LUT_W-1:0] rom [QN];

    for (genvar k = 0; k < QN; k++) begin : g_rom
        localparam int VAL = int'(real'(AMP) * $sin(HALF_PI * real'(k) / real'(QN)));
        assign rom[k] = LUT_W'(VAL);
    end

    function automatic logic signed [LUT_W-1:0] wave(input logic [ADDR_W-1:0] a);
        logic [1:0]              quad;
        logic [QW-1:0]           idx;
        logic [QW-1:0]           mir;
        logic signed [LUT_W-1:0] mag;
        quad = a[ADDR_W-1 -: 2];
        idx  = a[QW-1:0];
        mir  = ~idx + 1'b1;
        if (quad[0]) begin
            mag = (idx == '0) ? LUT_W'(AMP) : rom[mir];
        end else begin
            mag = rom[idx];
        end
        return quad[1] ? -mag : mag;
    endfunction

    always_comb begin
        sin_v = wave(addr);
        cos_v = wave(addr + ADDR_W'(QN));
    end
endmodule

// File: rtl/nco_round_sat.sv
module nco_round_sat #(
    parameter int IN_W  = 16,
    parameter int K_W   = 17,
    parameter int OUT_W = 16,
    parameter int FRAC  = 15
) (
    input  logic signed [IN_W-1:0]  x,
    input  logic signed [K_W-1:0]   k,
    output logic signed [OUT_W-1:0] y
);
    localparam int PW = IN_W + K_W;
    localparam int SW = PW - FRAC;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
    localparam logic signed [SW-1:0] MAXS = SW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINS = SW'(-(1 << (OUT_W - 1)));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [SW-1:0] shf;

    always_comb begin
        prod = PW'(x) * PW'(k);
        rnd  = prod + HALF;
        shf  = SW'(rnd >>> FRAC);
        if (shf > MAXS) begin
            y = OUT_W'(MAXS);
        end else if (shf < MINS) begin
            y = OUT_W'(MINS);
        end else begin
            y = OUT_W'(shf);
        end
    end
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
    import nco_mix_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 12,
    parameter int IN_W    = 16,
    parameter int LUT_W   = 16,
    parameter int OUT_W   = 16,
    parameter int PD_W    = 12,
    parameter int AD_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_addr,
    input  logic [PHASE_W-1:0]        cfg_wdata,
    input  logic                      in_valid,
    input  logic signed [IN_W-1:0]    in_sample,
    output logic                      out_valid,
    output logic signed [OUT_W-1:0]   out_i,
    output logic signed [OUT_W-1:0]   out_q
);
    localparam int K_W  = LUT_W + 1;
    localparam int FRAC = LUT_W - 1;

    typedef struct packed {
        logic [PHASE_W-1:0]      freq;
        logic [PHASE_W-1:0]      offs;
        logic                    pd_en;
        logic                    ad_en;
        logic                    v1;
        logic signed [IN_W-1:0]  x1;
        logic [ADDR_W-1:0]       a1;
        logic signed [AD_W-1:0]  d1;
        logic                    v2;
        logic signed [IN_W-1:0]  x2;
        logic signed [K_W-1:0]   s2;
        logic signed [K_W-1:0]   c2;
        logic                    v3;
        logic signed [OUT_W-1:0] i3;
        logic signed [OUT_W-1:0] q3;
    } mix_st_t;

    mix_st_t st_d, st_q;

    logic [ADDR_W-1:0]       lut_addr;
    logic signed [AD_W-1:0]  amp_dith;
    logic [PHASE_W-1:0]      acc_val;
    logic [PHASE_W-1:0]      freq_cur;
    logic signed [LUT_W-1:0] sin_v;
    logic signed [LUT_W-1:0] cos_v;
    logic signed [K_W-1:0]   neg_s2;
    logic signed [OUT_W-1:0] i_res;
    logic signed [OUT_W-1:0] q_res;

    nco_phase_gen #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W),
        .PD_W    (PD_W),
        .AD_W    (AD_W)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .freq     (st_q.freq),
        .offs     (st_q.offs),
        .pd_en    (st_q.pd_en),
        .ad_en    (st_q.ad_en),
        .addr     (lut_addr),
        .amp_dith (amp_dith),
        .acc_out  (acc_val)
    );

    nco_sincos_lut #(
        .ADDR_W (ADDR_W),
        .LUT_W  (LUT_W)
    ) u_lut (
        .addr  (st_q.a1),
        .sin_v (sin_v),
        .cos_v (cos_v)
    );

    nco_round_sat #(
        .IN_W  (IN_W),
        .K_W   (K_W),
        .OUT_W (OUT_W),
        .FRAC  (FRAC)
    ) u_rs_i (
        .x (st_q.x2),
        .k (st_q.c2),
        .y (i_res)
    );

    nco_round_sat #(
        .IN_W  (IN_W),
        .K_W   (K_W),
        .OUT_W (OUT_W),
        .FRAC  (FRAC)
    ) u_rs_q (
        .x (st_q.x2),
        .k (neg_s2),
        .y (q_res)
    );

    assign freq_cur = st_q.freq;
    assign neg_s2   = -st_q.s2;

    always_comb begin
        st_d = st_q;

        if (cfg_we) begin
            case (cfg_addr)
                REG_FREQ: st_d.freq = cfg_wdata;
                REG_OFFS: st_d.offs = cfg_wdata;
                REG_DITH: begin
                    st_d.pd_en = cfg_wdata[0];
                    st_d.ad_en = cfg_wdata[1];
                end
                default: ;
            endcase
        end

        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.x1 = in_sample;
            st_d.a1 = lut_addr;
            st_d.d1 = amp_dith;
        end

        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.x2 = st_q.x1;
            st_d.s2 = K_W'(sin_v) + K_W'(st_q.d1);
            st_d.c2 = K_W'(cos_v) + K_W'(st_q.d1);
        end

        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.i3 = i_res;
            st_d.q3 = q_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.v3;
    assign out_i     = st_q.i3;
    assign out_q     = st_q.q3;
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q,
    input logic [PHASE_W-1:0]      acc,
    input logic [PHASE_W-1:0]      freq
);
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= 2'd0;
        end else if (cnt != 2'd3) begin
            cnt <= cnt + 2'd1;
        end
    end

    // R1: pipeline stays empty right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (cnt != 2'd3) |-> !out_valid);

    // R6: fixed three-cycle latency
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: outputs change only with out_valid
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        ((cnt == 2'd3) && (!$stable(out_i) || !$stable(out_q))) |-> out_valid);

    // R3: accumulator frozen without a sample
    a_r3_acc_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc));

    // R3: accumulator steps by the tuning word per sample
    a_r3_acc_step: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (acc == $past(acc + freq)));
endmodule

bind nco_mixer nco_mixer_chk #(
    .PHASE_W (PHASE_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .acc       (acc_val),
    .freq      (freq_cur)
);

// File: tb/tb_nco_mixer.sv
module tb_nco_mixer;
    localparam int CLK_PERIOD = 10;
    localparam int AMP        = 32767;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = 2'd0;
    logic [31:0]        cfg_wdata = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic signed [15:0] got_i[$];
    logic signed [15:0] got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_mixer dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_i.push_back(out_i);
            got_q.push_back(out_q);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd_sat(input int x, input int k);
        longint p;
        p = longint'(x) * longint'(k) + 64'sd16384;
        p = p >>> 15;
        if (p > 32767) return 32767;
        if (p < -32768) return -32768;
        return int'(p);
    endfunction

    function automatic int cos_q(input int q);
        case (q % 4)
            0: return AMP;
            2: return -AMP;
            default: return 0;
        endcase
    endfunction

    function automatic int sin_q(input int q);
        case (q % 4)
            1: return AMP;
            3: return -AMP;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_i.delete();
        got_q.delete();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int x);
        in_valid = 1'b1; in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 out_i after reset", int'(out_i), 0);
        chk("R1 out_q after reset", int'(out_q), 0);
        send(1000);
        drain();
        chk("R1 sample count", got_i.size(), 1);
        if (got_i.size() == 1) begin
            chk("R1 zero phase I", int'(got_i[0]), rnd_sat(1000, AMP));
            chk("R1 zero phase Q", int'(got_q[0]), 0);
        end
    endtask

    task automatic t_quadrants();
        int xs[8] = '{1000, -2000, 32767, -32768, 12345, -1, 20000, -15000};
        do_reset();
        wr(2'd0, 32'h4000_0000);
        foreach (xs[k]) send(xs[k]);
        drain();
        chk("R3 quadrant count", got_i.size(), 8);
        for (int k = 0; k < 8 && k < got_i.size(); k++) begin
            chk("R4 R5 quadrant I", int'(got_i[k]), rnd_sat(xs[k], cos_q(k)));
            chk("R4 R5 quadrant Q", int'(got_q[k]), rnd_sat(xs[k], -sin_q(k)));
        end
    endtask

    task automatic t_offset();
        do_reset();
        wr(2'd1, 32'h8000_0000);
        send(5000);
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h4000_0000;
        send(6000);
        cfg_we = 1'b0;
        send(7000);
        wr(2'd3, 32'hFFFF_FFFF);
        send(8000);
        drain();
        chk("R2 offset count", got_i.size(), 4);
        if (got_i.size() == 4) begin
            chk("R2 offset half turn I", int'(got_i[0]), rnd_sat(5000, -AMP));
            chk("R2 same-cycle write uses old offset", int'(got_i[1]), rnd_sat(6000, -AMP));
            chk("R2 new offset Q", int'(got_q[2]), rnd_sat(7000, -AMP));
            chk("R2 new offset I", int'(got_i[2]), 0);
            chk("R2 spare address ignored Q", int'(got_q[3]), rnd_sat(8000, -AMP));
            chk("R2 spare address ignored I", int'(got_i[3]), 0);
        end
    endtask

    task automatic t_gaps();
        int first_i;
        do_reset();
        wr(2'd0, 32'h4000_0000);
        send(3000);
        repeat (4) @(negedge clk);
        send(3000);
        repeat (2) @(negedge clk);
        send(3000);
        drain();
        chk("R3 gap count", got_i.size(), 3);
        for (int k = 0; k < 3 && k < got_i.size(); k++) begin
            chk("R3 gap phase I", int'(got_i[k]), rnd_sat(3000, cos_q(k)));
            chk("R3 gap phase Q", int'(got_q[k]), rnd_sat(3000, -sin_q(k)));
        end
        do_reset();
        send(-4000);
        chk("R6 latency cycle 1", int'(out_valid), 0);
        @(negedge clk);
        chk("R6 latency cycle 2", int'(out_valid), 0);
        @(negedge clk);
        chk("R6 latency cycle 3", int'(out_valid), 1);
        first_i = int'(out_i);
        chk("R6 output value", first_i, rnd_sat(-4000, AMP));
        @(negedge clk);
        chk("R6 single valid pulse", int'(out_valid), 0);
        repeat (2) @(negedge clk);
        chk("R6 output hold", int'(out_i), first_i);
    endtask

    task automatic t_pdither();
        int b1, q1, nz, bad;
        b1 = int'(32767.0 * $sin(1.5707963267948966 / 1024.0));
        q1 = rnd_sat(32767, -b1);
        do_reset();
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h0008_0000);
        for (int k = 0; k < 32; k++) send(32767);
        drain();
        chk("R7 mid-entry count", got_i.size(), 32);
        bad = 0;
        foreach (got_i[k]) if (got_q[k] != 0 || int'(got_i[k]) != rnd_sat(32767, AMP)) bad++;
        chk("R7 mid-entry samples moved", bad, 0);

        do_reset();
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h000F_F800);
        for (int k = 0; k < 64; k++) send(32767);
        drain();
        nz = 0; bad = 0;
        foreach (got_q[k]) begin
            if (got_q[k] != 0) nz++;
            if (got_q[k] != 0 && int'(got_q[k]) != q1) bad++;
        end
        chk("R7 boundary unexpected values", bad, 0);
        chk("R7 boundary crossings seen", int'(nz > 0 && nz < 64), 1);

        do_reset();
        wr(2'd1, 32'h000F_F800);
        for (int k = 0; k < 16; k++) send(32767);
        drain();
        nz = 0;
        foreach (got_q[k]) if (got_q[k] != 0) nz++;
        chk("R7 disabled no perturbation", nz, 0);
    endtask

    task automatic t_adither();
        int nz, sat, bad, q, ei;
        do_reset();
        wr(2'd2, 32'h2);
        for (int k = 0; k < 64; k++) send(-32768);
        drain();
        chk("R8 sample count", got_i.size(), 64);
        nz = 0; sat = 0; bad = 0;
        foreach (got_i[k]) begin
            q = int'(got_q[k]);
            if (q < -4 || q > 3) bad++;
            if (q != 0) nz++;
            ei = -32767 - q;
            if (ei < -32768) begin
                ei = -32768;
                sat++;
            end
            if (int'(got_i[k]) != ei) begin
                errors++;
                checks++;
                $display("FAIL R9 clamp actual %0d expected %0d", int'(got_i[k]), ei);
            end
        end
        chk("R8 dither range", bad, 0);
        chk("R8 dither active", int'(nz > 0), 1);
        chk("R9 saturation exercised", int'(sat > 0), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_quadrants();
        t_offset();
        t_gaps();
        t_pdither();
        t_adither();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule